// File: doc/BRIEF.md
# Audio Codec Control Register File

This block is the control register bank of an AC'97-style audio codec. Software reaches it through a simple synchronous port. The port carries a 7-bit address, 16-bit write data, a write enable and a registered 16-bit read result. The address names 128 locations of 16 bits each. The mixer, volume, power, extended-audio, sample-rate and identity registers sit at fixed even offsets, and each one comes out of reset with its own value. Every other location starts at zero and stores whatever software writes to it.

Writes are sorted by address into four kinds:

- **Store:** the full word is stored.
- **Soft reset:** any write to offset 0x00 reloads the whole default table. The written data is dropped.
- **Locked:** the identity registers ignore the write.
- **Masked:** the powerdown register keeps its low status nibble and takes the upper twelve bits from the write.

A write to the front DAC rate register also tells the sample path that the rate has changed. It does this through a small two-state machine:

- **RN_IDLE:** the strobe is low.
- **RN_PULSE:** the strobe is high for one cycle while the new rate is presented.

There are two transitions:

- **T_NOTIFY:** a DAC rate write is accepted, from either state, and the machine moves to RN_PULSE.
- **T_SETTLE:** a cycle in RN_PULSE passes with no new rate write, and the machine moves to RN_IDLE.

Top module: `codec_regbank`

## Requirements
- R1: After the hardware reset, the registers hold these values: 0x00=0x0D50, 0x02=0x8008, 0x04=0x8000, 0x06=0x8000, 0x0C=0x8008, 0x0E=0x8008, 0x10/0x12/0x14/0x16/0x18=0x8808, 0x1C=0x8000, 0x22=0x0101, 0x26=0x000F, 0x28=0x0001, 0x2C=0xBB80, 0x32=0xBB80, 0x7C=0x4E53, 0x7E=0x4331.
- R2: Every address that is not listed in R1 reads 0 until it is written. This includes all odd addresses.
- R3: A write of any data to address 0x00 returns every register to its R1/R2 value. The data is not stored, so address 0x00 then reads 0x0D50.
- R4: A write to 0x28, 0x7C or 0x7E leaves that register unchanged.
- R5: A write to 0x26 keeps bits [3:0] at their previous value and stores bits [15:4] from the write data.
- R6: A write to any other address stores all 16 bits. The value on `rd_data` after a clock edge is the content of location `addr` before that edge, so a read has one cycle of latency and a write is visible from the following cycle.
- R7: A write to 0x2C stores the word. `rate_chg` is then high for exactly the next cycle, with `rate_val` equal to the written word.
- R8: Writes to any address other than 0x2C leave `rate_chg` low and `rate_val` unchanged. `rate_val` is 0xBB80 after reset.
- R9: While the hardware reset is asserted, `rd_data` is 0 and `rate_chg` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous-style hardware reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 7 | Register location |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read of `addr` |
| rate_chg | output | 1 | One-cycle DAC rate change strobe |
| rate_val | output | 16 | Most recently written DAC rate |

## Verification
The bench first sweeps reads over all 128 locations after the hardware reset. This separates the listed defaults from the zero fill and from odd addresses.

It then runs four kinds of write patterns:

- Plain stores with a same-address read-back. These expose read-before-write ordering.
- Writes to each locked and masked register. These tell the rule classes apart.
- A soft reset written with nonzero data, after scribbling over several locations. This shows that the whole table is restored and that the data is not kept.
- Single and back-to-back DAC rate writes, mixed with writes to the neighbouring ADC rate register. These show that the strobe lasts one cycle per write and follows only the right address.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;

    localparam int REG_AW = 7;
    localparam int REG_DW = 16;

    localparam logic [REG_AW-1:0] A_SOFT_RST = 7'h00;
    localparam logic [REG_AW-1:0] A_PWR_STAT = 7'h26;
    localparam logic [REG_AW-1:0] A_EXT_ID   = 7'h28;
    localparam logic [REG_AW-1:0] A_DAC_RATE = 7'h2C;
    localparam logic [REG_AW-1:0] A_ID_HI    = 7'h7C;
    localparam logic [REG_AW-1:0] A_ID_LO    = 7'h7E;

    typedef enum logic [1:0] {
        WR_STORE,
        WR_SOFT_RESET,
        WR_LOCKED,
        WR_MASKED
    } wr_class_e;

    typedef enum logic {
        RN_IDLE,
        RN_PULSE
    } rate_state_e;

    function automatic logic [REG_DW-1:0] reset_word(input logic [REG_AW-1:0] a);
        logic [REG_DW-1:0] w;
        case (a)
            7'h00:                          w = 16'h0D50;
            7'h02, 7'h0C, 7'h0E:            w = 16'h8008;
            7'h04, 7'h06, 7'h1C:            w = 16'h8000;
            7'h10, 7'h12, 7'h14,
            7'h16, 7'h18:                   w = 16'h8808;
            7'h22:                          w = 16'h0101;
            7'h26:                          w = 16'h000F;
            7'h28:                          w = 16'h0001;
            7'h2C, 7'h32:                   w = 16'hBB80;
            7'h7C:                          w = 16'h4E53;
            7'h7E:                          w = 16'h4331;
            default:                        w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/codec_write_rules.sv
module codec_write_rules
    import codec_regs_pkg::*;
#(
    parameter int ADDR_W = REG_AW,
    parameter int DATA_W = REG_DW,
    parameter int KEEP_W = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] cur_word,
    output logic              store_en,
    output logic              soft_rst,
    output logic              rate_wr,
    output logic [DATA_W-1:0] new_word
);

    localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((1 << KEEP_W) - 1);

    wr_class_e cls;

    always_comb begin
        unique case (addr)
            A_SOFT_RST:                   cls = WR_SOFT_RESET;
            A_EXT_ID, A_ID_HI, A_ID_LO:   cls = WR_LOCKED;
            A_PWR_STAT:                   cls = WR_MASKED;
            default:                      cls = WR_STORE;
        endcase
    end

    always_comb begin
        store_en = 1'b0;
        soft_rst = 1'b0;
        new_word = wr_data;
        if (wr_en) begin
            unique case (cls)
                WR_SOFT_RESET: soft_rst = 1'b1;
                WR_LOCKED:     store_en = 1'b0;
                WR_MASKED: begin
                    store_en = 1'b1;
                    new_word = (wr_data & ~KEEP_MASK) | (cur_word & KEEP_MASK);
                end
                default:       store_en = 1'b1;
            endcase
        end
    end

    assign rate_wr = wr_en && (addr == A_DAC_RATE);

endmodule

// File: rtl/codec_reg_array.sv
module codec_reg_array
    import codec_regs_pkg::*;
#(
    parameter int ADDR_W = REG_AW,
    parameter int DATA_W = REG_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              store_en,
    input  logic              soft_rst,
    input  logic [DATA_W-1:0] new_word,
    output logic [DATA_W-1:0] cur_word,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                mem[i] <= reset_word(ADDR_W'(i));
            end else if (store_en && (addr == ADDR_W'(i))) begin
                mem[i] <= new_word;
            end
        end
    end

    assign cur_word = mem[addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= cur_word;
        end
    end

    // Status nibble of the powerdown register never moves off its reset value.
    assert_pwr_nibble_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem[A_PWR_STAT][3:0] == 4'hF);

    // Soft reset restores the table, including registers far from address 0.
    assert_soft_restore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mem[7'h02] == 16'h8008) && (mem[A_ID_HI] == 16'h4E53)
                     && (mem[A_SOFT_RST] == 16'h0D50));

    // Identity registers are never altered by writes.
    assert_id_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem[A_EXT_ID] == 16'h0001) && (mem[A_ID_HI] == 16'h4E53)
        && (mem[A_ID_LO] == 16'h4331));

endmodule

// File: rtl/codec_rate_notify.sv
module codec_rate_notify
    import codec_regs_pkg::*;
#(
    parameter int DATA_W = REG_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rate_chg,
    output logic [DATA_W-1:0] rate_val
);

    rate_state_e state, state_nx;

    always_comb begin
        unique case (state)
            RN_IDLE:  state_nx = rate_wr ? RN_PULSE : RN_IDLE;
            RN_PULSE: state_nx = rate_wr ? RN_PULSE : RN_IDLE;
            default:  state_nx = RN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RN_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_val <= reset_word(A_DAC_RATE);
        end else if (rate_wr) begin
            rate_val <= wr_data;
        end
    end

    assign rate_chg = (state == RN_PULSE);

    // Strobe appears only in the cycle after a DAC rate write.
    assert_strobe_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rate_chg |-> $past(rate_wr));

    // A rate write always produces the strobe carrying its data.
    assert_strobe_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rate_wr |=> rate_chg && (rate_val == $past(wr_data)));

    // Without a rate write the announced rate holds.
    assert_rate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_wr |=> $stable(rate_val));

endmodule

// File: rtl/codec_regbank.sv
module codec_regbank
    import codec_regs_pkg::*;
#(
    parameter int ADDR_W = REG_AW,
    parameter int DATA_W = REG_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rate_chg,
    output logic [DATA_W-1:0] rate_val
);

    logic              store_en;
    logic              soft_rst;
    logic              rate_wr;
    logic [DATA_W-1:0] new_word;
    logic [DATA_W-1:0] cur_word;

    codec_write_rules #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rules (
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .cur_word (cur_word),
        .store_en (store_en),
        .soft_rst (soft_rst),
        .rate_wr  (rate_wr),
        .new_word (new_word)
    );

    codec_reg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .store_en (store_en),
        .soft_rst (soft_rst),
        .new_word (new_word),
        .cur_word (cur_word),
        .rd_data  (rd_data)
    );

    codec_rate_notify #(.DATA_W(DATA_W)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_wr  (rate_wr),
        .wr_data  (wr_data),
        .rate_chg (rate_chg),
        .rate_val (rate_val)
    );

    // Reset state of the visible outputs.
    assert_reset_outputs_R9: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0) && !rate_chg);

endmodule

// File: tb/test_codec_regbank.sv
module test_codec_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rate_chg;
    logic [15:0] rate_val;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    int model [128];
    int exp_rate;

    always #2.5 clk = ~clk;

    codec_regbank i_codec_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .rate_chg(rate_chg),
        .rate_val(rate_val)
    );

    function automatic int dflt(input int a);
        case (a)
            'h00: return 'h0D50;
            'h02, 'h0C, 'h0E: return 'h8008;
            'h04, 'h06, 'h1C: return 'h8000;
            'h10, 'h12, 'h14, 'h16, 'h18: return 'h8808;
            'h22: return 'h0101;
            'h26: return 'h000F;
            'h28: return 'h0001;
            'h2C, 'h32: return 'hBB80;
            'h7C: return 'h4E53;
            'h7E: return 'h4331;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic load_defaults();
        for (int i = 0; i < 128; i++) model[i] = dflt(i);
    endtask

    // One clock: drive at negedge, compare at the next negedge.
    task automatic step(input bit w, input int a, input int d, input string tag);
        int exp_rd;
        bit exp_chg;
        wr_en = w; addr = 7'(a); wr_data = 16'(d);
        exp_rd = model[a];
        exp_chg = w && (a == 'h2C);
        if (w) begin
            if (a == 'h00) load_defaults();
            else if (a == 'h28 || a == 'h7C || a == 'h7E) ;
            else if (a == 'h26) model[a] = (d & 'hFFF0) | (model[a] & 'hF);
            else model[a] = d & 'hFFFF;
            if (a == 'h2C) exp_rate = d & 'hFFFF;
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check(tag, "rd_data", int'(rd_data), exp_rd);
        check(exp_chg ? "R7" : "R8", "rate_chg", int'(rate_chg), int'(exp_chg));
        check(exp_chg ? "R7" : "R8", "rate_val", int'(rate_val), exp_rate);
    endtask

    initial begin
        load_defaults();
        exp_rate = 'hBB80;
        repeat (3) @(negedge clk);
        // R9: outputs quiet during reset
        check("R9", "rd_data in reset", int'(rd_data), 0);
        check("R9", "rate_chg in reset", int'(rate_chg), 0);
        rst_n = 1'b1;

        // R1 / R2: default sweep over every location
        for (int a = 0; a < 128; a++) step(0, a, 0, (dflt(a) != 0) ? "R1" : "R2");

        // R6: plain stores, same-address read shows the old value first
        step(1, 'h40, 'hA5A5, "R6");
        step(0, 'h40, 0, "R6");
        step(1, 'h02, 'h1234, "R6");
        step(1, 'h02, 'hFFFF, "R6");
        step(0, 'h02, 0, "R6");
        step(1, 'h33, 'h5A5A, "R6");
        step(0, 'h33, 0, "R6");
        step(1, 'h32, 'h1F40, "R8");
        step(0, 'h32, 0, "R8");

        // R4: identity registers locked
        step(1, 'h28, 'hFFFF, "R4");
        step(1, 'h7C, 'h0000, "R4");
        step(1, 'h7E, 'h1111, "R4");
        step(0, 'h28, 0, "R4");
        step(0, 'h7C, 0, "R4");
        step(0, 'h7E, 0, "R4");

        // R5: powerdown status nibble kept
        step(1, 'h26, 'hABC0, "R5");
        step(0, 'h26, 0, "R5");
        step(1, 'h26, 'h0000, "R5");
        step(0, 'h26, 0, "R5");

        // R7: DAC rate writes, single and back to back
        step(1, 'h2C, 'hAC44, "R7");
        step(0, 'h2C, 0, "R7");
        step(1, 'h2C, 'h5622, "R7");
        step(1, 'h2C, 'h7D00, "R7");
        step(0, 'h10, 0, "R8");
        step(0, 'h2C, 0, "R7");

        // R3: soft reset with nonzero data restores everything
        step(1, 'h00, 'h1234, "R3");
        for (int a = 0; a < 128; a++) step(0, a, 0, "R3");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule